// File: doc/BRIEF.md
# Byte-Addressed Word Memory with Access-Type Control

This block is a single-port storage array organised as 32-bit words but addressed by byte. Each request carries a 32-bit byte address, 32-bit write data, an enable and a 2-bit operation code. The code selects one of four operations: a full-word read, a single-byte write, a halfword write or a full-word write. The block turns the operation and the low address bits into per-byte lane write strobes for the word that the address selects. Alignment rules depend on the operation. A byte may sit anywhere. A halfword must be even. A word, whether read or written, must sit on a multiple of four. A request that breaks its rule is refused and flagged.

Word storage depth is a parameter and must be a power of two. The word index is taken from the address bits just above the byte offset, and every higher address bit is ignored, so the space aliases. Each byte lane is a separate array with a registered read port, so each lane maps onto block RAM. Read data, the read-valid flag and the error flag all appear one clock after the request. Byte order is little-endian: byte address offset 0 is data bits [7:0].

Top module: `bytemem_top`

## Requirements
- R1: While `rst` is high at a rising edge, `rvalid`, `err` and `rdata` are all 0 after that edge.
- R2: A request with `en` low writes nothing, and the next cycle shows `rvalid` = 0 and `err` = 0.
- R3: Code 2'b00 with `addr[1:0]` = 0 is a word read. One cycle later `rvalid` = 1 and `rdata` holds the word at index `addr[2 +: log2(DEPTH)]`, with the byte at offset k on bits [8k+7:8k].
- R4: Code 2'b01 writes `wdata[7:0]` into byte offset `addr[1:0]` of the indexed word, for any value of `addr[1:0]`. The other three bytes of that word do not change.
- R5: Code 2'b10 with `addr[0]` = 0 writes `wdata[15:0]`. With `addr[1]` = 0 it goes to bytes 1:0, and with `addr[1]` = 1 it goes to bytes 3:2. The other half of the word does not change.
- R6: Code 2'b11 with `addr[1:0]` = 0 replaces all four bytes of the indexed word with `wdata`.
- R7: Code 2'b10 with `addr[0]` = 1 writes nothing and raises `err` for one cycle, one cycle later.
- R8: Code 2'b11 or 2'b00 with `addr[1:0]` ≠ 0 writes nothing, raises `err` one cycle later and leaves `rvalid` at 0.
- R9: Address bits above `addr[2 + log2(DEPTH) - 1]` have no effect. Two addresses that differ only there reach the same word.
- R10: `rdata` keeps its value in every cycle where `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| en | input | 1 | Request enable; no action when low |
| ctl | input | 2 | Operation: 00 word read, 01 byte write, 10 halfword write, 11 word write |
| addr | input | 32 | Byte address |
| wdata | input | 32 | Write data, least significant bits used for narrow writes |
| rdata | output | 32 | Registered read data, little-endian |
| rvalid | output | 1 | High one cycle after an accepted word read |
| err | output | 1 | High one cycle after a misaligned request |

## Verification
The bench targets the lane steering of narrow writes. It writes each byte offset and both halfword halves, then reads the whole word back. A design with a wrong lane shift or a big-endian order would corrupt a neighbouring byte or leave the target byte unchanged. Misaligned halfword and word requests are followed by reads of the same word, which exposes a design that raises `err` but still commits a partial or shifted write. Requests with `en` low but a write code present, writes at aliased high addresses, and idle cycles after a read all target the same set of bugs. Such a design would write while disabled, decode high address bits, or let `rdata` drift when no read was accepted.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;
  typedef enum logic [1:0] {
    OP_RD_WORD = 2'b00,
    OP_WR_BYTE = 2'b01,
    OP_WR_HALF = 2'b10,
    OP_WR_WORD = 2'b11
  } memop_e;

  localparam int LANE_W = 8;
  localparam int LANES  = 4;
  localparam int WORD_W = LANE_W * LANES;
endpackage

// File: rtl/bytemem_decode.sv
// Turns operation code and low address bits into lane strobes, lane data,
// read request and misalignment flag. Purely combinational.
module bytemem_decode
  import bytemem_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic              en,
  input  memop_e            op,
  input  logic [IDXW+1:0]   addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [IDXW-1:0]   idx,
  output logic [LANES-1:0]  lane_we,
  output logic [WORD_W-1:0] lane_wd,
  output logic              rd_req,
  output logic              misalign
);
  always_comb begin
    idx      = addr[IDXW+1:2];
    lane_we  = '0;
    lane_wd  = wdata;
    rd_req   = 1'b0;
    misalign = 1'b0;
    if (en) begin
      case (op)
        OP_RD_WORD: begin
          if (addr[1:0] != 2'b00) misalign = 1'b1;
          else                    rd_req   = 1'b1;
        end
        OP_WR_BYTE: begin
          lane_we = 4'b0001 << addr[1:0];
          lane_wd = {LANES{wdata[LANE_W-1:0]}};
        end
        OP_WR_HALF: begin
          if (addr[0]) begin
            misalign = 1'b1;
          end else begin
            lane_we = addr[1] ? 4'b1100 : 4'b0011;
            lane_wd = {2{wdata[2*LANE_W-1:0]}};
          end
        end
        default: begin
          if (addr[1:0] != 2'b00) misalign = 1'b1;
          else                    lane_we  = '1;
        end
      endcase
    end
  end
endmodule

// File: rtl/bytemem_lane.sv
// One byte lane: simple dual-use array with a registered read port.
module bytemem_lane #(
  parameter int DEPTH = 256,
  parameter int IDXW  = 8,
  parameter int W     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic            re,
  input  logic [IDXW-1:0] idx,
  input  logic [W-1:0]    wd,
  output logic [W-1:0]    rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     rd <= '0;
    else if (re) rd <= mem[idx];
  end
endmodule

// File: rtl/bytemem_top.sv
module bytemem_top
  import bytemem_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [1:0]  ctl,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        err
);
  localparam int IDXW = $clog2(DEPTH);

  memop_e              op;
  logic [IDXW-1:0]     idx;
  logic [LANES-1:0]    lane_we;
  logic [WORD_W-1:0]   lane_wd;
  logic                rd_req;
  logic                misalign;

  assign op = memop_e'(ctl);

  bytemem_decode #(.IDXW(IDXW)) u_dec (
    .en       (en),
    .op       (op),
    .addr     (addr[IDXW+1:0]),
    .wdata    (wdata),
    .idx      (idx),
    .lane_we  (lane_we),
    .lane_wd  (lane_wd),
    .rd_req   (rd_req),
    .misalign (misalign)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bytemem_lane #(.DEPTH(DEPTH), .IDXW(IDXW), .W(LANE_W)) u_lane (
      .clk (clk),
      .rst (rst),
      .we  (lane_we[g]),
      .re  (rd_req),
      .idx (idx),
      .wd  (lane_wd[g*LANE_W +: LANE_W]),
      .rd  (rdata[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_req;
      err    <= misalign;
    end
  end
endmodule

// File: rtl/bytemem_chk.sv
module bytemem_chk #(
  parameter int IDXW = 8
) (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [1:0]  ctl,
  input logic [31:0] addr,
  input logic [31:0] wdata,
  input logic [31:0] rdata,
  input logic        rvalid,
  input logic        err,
  input logic [3:0]  lane_we
);
  logic        ww_q;
  logic [31:2] wa_q;
  logic [31:0] wd_q;

  always_ff @(posedge clk) begin
    ww_q <= !rst && en && ctl == 2'b11 && addr[1:0] == 2'b00;
    wa_q <= addr[31:2];
    wd_q <= wdata;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!rvalid && !err && rdata == 32'h0));

  a_r2_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !en |-> lane_we == 4'b0000);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!rvalid && !err));

  a_r3_read_valid: assert property (@(posedge clk) disable iff (rst)
    (en && ctl == 2'b00 && addr[1:0] == 2'b00) |=> (rvalid && !err));

  a_r4_one_lane: assert property (@(posedge clk) disable iff (rst)
    (en && ctl == 2'b01) |-> $countones(lane_we) == 1);

  a_r5_two_lanes: assert property (@(posedge clk) disable iff (rst)
    (en && ctl == 2'b10 && !addr[0]) |-> $countones(lane_we) == 2);

  a_r7_half_misalign: assert property (@(posedge clk) disable iff (rst)
    (en && ctl == 2'b10 && addr[0]) |=> (err && !rvalid));

  a_r8_word_misalign: assert property (@(posedge clk) disable iff (rst)
    (en && (ctl == 2'b00 || ctl == 2'b11) && addr[1:0] != 2'b00)
      |=> (err && !rvalid));

  a_r9_alias_read: assert property (@(posedge clk) disable iff (rst)
    (ww_q && en && ctl == 2'b00 && addr[1:0] == 2'b00 &&
     addr[IDXW+1:2] == wa_q[IDXW+1:2] && addr[31:IDXW+2] != wa_q[31:IDXW+2])
      |=> rdata == $past(wd_q));

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !rvalid |-> $stable(rdata));
endmodule

bind bytemem_top bytemem_chk #(.IDXW(IDXW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .en      (en),
  .ctl     (ctl),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .rvalid  (rvalid),
  .err     (err),
  .lane_we (lane_we)
);

// File: tb/tb_bytemem_top.sv
`timescale 1ns/1ps
module tb_bytemem_top;
  localparam int DEPTH = 256;
  localparam int IDXW  = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [1:0]  ctl = 2'b00;
  logic [31:0] addr = 32'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        err;

  always #2 clk = ~clk;

  bytemem_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .en(en), .ctl(ctl), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err)
  );

  typedef struct packed {
    logic        v;
    logic        e;
    logic [31:0] d;
  } exp_t;

  exp_t        exp_q[$];
  string       tag_q[$];
  logic [7:0]  ref_mem [DEPTH*4];
  logic [31:0] last_rd = 32'h0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  function automatic logic [31:0] ref_word(int i);
    return {ref_mem[i*4+3], ref_mem[i*4+2], ref_mem[i*4+1], ref_mem[i*4]};
  endfunction

  // Driver: applies one request and pushes the expected outcome.
  task automatic op(bit e, logic [1:0] c, logic [31:0] a, logic [31:0] d, string tag);
    int   i;
    int   l;
    bit   mis;
    exp_t x;
    i = int'(a[2 +: IDXW]);
    l = int'(a[1:0]);
    @(negedge clk);
    en = e; ctl = c; addr = a; wdata = d;
    mis = e && ((((c == 2'b00) || (c == 2'b11)) && l != 0) || (c == 2'b10 && a[0]));
    if (e && !mis) begin
      case (c)
        2'b01: ref_mem[i*4+l] = d[7:0];
        2'b10: begin
          ref_mem[i*4+l]   = d[7:0];
          ref_mem[i*4+l+1] = d[15:8];
        end
        2'b11: for (int k = 0; k < 4; k++) ref_mem[i*4+k] = d[k*8 +: 8];
        default: ;
      endcase
    end
    x.v = e && c == 2'b00 && !mis;
    x.e = mis;
    if (x.v) last_rd = ref_word(i);
    x.d = last_rd;
    exp_q.push_back(x);
    tag_q.push_back(tag);
  endtask

  // Monitor: one expected item per issued request, compared after the edge.
  initial begin
    forever begin
      exp_t  x;
      string t;
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({rvalid, err, rdata} !== x) begin
          errors++;
          $display("FAIL %s: actual rvalid=%b err=%b rdata=%h expected rvalid=%b err=%b rdata=%h",
                   t, rvalid, err, rdata, x.v, x.e, x.d);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (rvalid !== 1'b0 || err !== 1'b0 || rdata !== 32'h0) begin
      errors++;
      $display("FAIL R1: actual rvalid=%b err=%b rdata=%h expected 0 0 00000000",
               rvalid, err, rdata);
    end
    @(negedge clk);
    rst = 1'b0;

    // R6: fill every word
    for (int i = 0; i < DEPTH; i++)
      op(1, 2'b11, i*4, 32'hA5000000 ^ (i * 32'h01030507), "R6");
    // R3: read back several words
    for (int i = 0; i < DEPTH; i += 37) op(1, 2'b00, i*4, 32'h0, "R3");
    op(1, 2'b00, (DEPTH-1)*4, 32'h0, "R3");

    // R2: disabled write codes change nothing
    op(0, 2'b11, 32'h10, 32'hDEADBEEF, "R2");
    op(0, 2'b01, 32'h11, 32'h000000EE, "R2");
    op(0, 2'b00, 32'h13, 32'h0, "R2");
    op(1, 2'b00, 32'h10, 32'h0, "R2");

    // R10: rdata holds across idle cycles and accepted writes
    op(1, 2'b00, 32'h20, 32'h0, "R3");
    op(0, 2'b00, 32'h24, 32'h0, "R10");
    op(0, 2'b11, 32'h28, 32'h0, "R10");
    op(1, 2'b11, 32'h2C, 32'h01020304, "R10");
    op(1, 2'b01, 32'h31, 32'h0000007F, "R10");

    // R4: every byte offset
    for (int l = 0; l < 4; l++) begin
      op(1, 2'b01, 32'h40 + l, 32'hFFFFFF00 | (l*17 + 1), "R4");
      op(1, 2'b00, 32'h40, 32'h0, "R4");
    end

    // R5: both halfword halves
    op(1, 2'b10, 32'h50, 32'hABCD1234, "R5");
    op(1, 2'b00, 32'h50, 32'h0, "R5");
    op(1, 2'b10, 32'h52, 32'h5555BEEF, "R5");
    op(1, 2'b00, 32'h50, 32'h0, "R5");

    // R7: odd halfword addresses
    op(1, 2'b10, 32'h61, 32'h0000CAFE, "R7");
    op(1, 2'b10, 32'h63, 32'h0000F00D, "R7");
    op(1, 2'b00, 32'h60, 32'h0, "R7");

    // R8: unaligned word writes and reads
    op(1, 2'b11, 32'h71, 32'h11223344, "R8");
    op(1, 2'b11, 32'h72, 32'h55667788, "R8");
    op(1, 2'b11, 32'h73, 32'h99AABBCC, "R8");
    op(1, 2'b00, 32'h73, 32'h0, "R8");
    op(1, 2'b00, 32'h72, 32'h0, "R8");
    op(1, 2'b00, 32'h70, 32'h0, "R8");

    // R9: high address bits alias
    op(1, 2'b11, 32'h80000084, 32'h13579BDF, "R9");
    op(1, 2'b00, 32'h00000084, 32'h0, "R9");
    op(1, 2'b01, 32'hFFFFF805, 32'h000000C3, "R9");
    op(1, 2'b00, 32'h00000004, 32'h0, "R9");
    op(1, 2'b10, 32'h12345402, 32'h00007E81, "R9");
    op(1, 2'b00, 32'h00000000, 32'h0, "R9");

    // Mixed random traffic, misaligned cases included (R3 to R8)
    for (int n = 0; n < 3000; n++)
      op(($urandom % 10) != 0, 2'($urandom), $urandom, $urandom, "MIX R3-R8");

    @(negedge clk);
    en = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule